// File: doc/BRIEF.md
# Clocked Cycle Controller for an Asynchronous 256x4 Static RAM

This block sits between a synchronous host and an asynchronous 256-word by 4-bit static RAM that has separate data-in and data-out pins. It takes one read or write request at a time through a valid/ready handshake. It then plays out the RAM's control waveform: the two chip selects, the read/write strobe, the output-disable line, the address and the write data. The waveform is built from whole clock cycles. Every phase length is worked out at elaboration time from a nanosecond minimum and the clock period.

A write runs through three phases: an address-setup phase with the strobe high, a strobe-low pulse, and a recovery phase with the strobe high again. Address, data and selects stay held through all three phases, and `wr_done` then pulses. The pulse is stretched to cover the data-setup, select-setup and, in common-I/O mode, output-disable-setup minimums. The recovery is stretched so the whole write meets the minimum write-cycle time. A read holds the address with the RAM selected and its output enabled for the longer of the access time and the read-cycle time. It samples the RAM data on the last cycle and presents it with a one-cycle `rd_valid`. Outside a read the output-disable line is held high, so in common-I/O systems the RAM output is already off well before any write strobe.

Top module: `sram_cycle_ctl`

## Requirements
- R1: Each timing minimum converts to max(1, ceil(ns / CLK_PERIOD_NS)) cycles. With the defaults (8 ns clock) this gives address setup 7, strobe pulse 32, recovery 24 and read access 57 cycles.
- R2: During and directly after reset the controller is idle: `req_ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_odis`=1, `rd_valid`=0, `wr_done`=0. An asynchronous reset in mid-write returns all RAM controls to this state at once.
- R3: A write first selects the RAM (`mem_sel_n`=0, `mem_sel`=1) and drives address and data with `mem_wr_n`=1 for exactly the address-setup cycle count.
- R4: The strobe `mem_wr_n` is then low for exactly max(pulse, data setup, select setup, output-disable setup if COMMON_IO) cycles, and it is low only while the RAM is selected.
- R5: After the strobe rises, address, data and selects are held for max(recovery, write-cycle minus setup minus pulse) cycles. `wr_done` then pulses for one cycle, in the first idle cycle, which is the 63rd cycle after the accepting edge with the defaults.
- R6: `mem_odis` stays high throughout every write, from the first selected cycle to deselection.
- R7: A read selects the RAM with `mem_wr_n`=1 and `mem_odis`=0 for exactly the access cycle count. `mem_dout` is sampled on the last of those cycles, and `rd_data` is shown with a one-cycle `rd_valid` in the next cycle (57 cycles after the accepting edge with the defaults).
- R8: `req_ready` is high only when idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests presented while `req_ready` is low are ignored and do not change the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read data |
| wr_done | output | 1 | One-cycle write-complete strobe |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_wr_n | output | 1 | RAM strobe, low = write |
| mem_odis | output | 1 | RAM output disable, high = off |
| mem_din | output | DATA_W | Data to the RAM input pins |
| mem_dout | input | DATA_W | Data from the RAM output pins |

## Verification
Take the clock edge that accepts a request as edge 0. With the defaults, `wr_done` is due at the falling edge after edge 63 and `rd_valid` at the falling edge after edge 57. The bench counts falling edges from the accepting edge and compares the count with the latency it derives from the nanosecond figures itself. A behavioural RAM model samples every falling edge and measures the length of each select window segment in cycles: strobe high before the pulse, strobe low, strobe high after it, and output-enabled read. It checks each length at the moment of deselection. Data is written into the model on the first sample after the strobe rises, so a wrong hold shows up in later read-back values.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WPUL = 3'd2,
    PH_WREC = 3'd3,
    PH_RACC = 3'd4
  } phase_e;

  // whole cycles covering a minimum in ns, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery stretched so setup + pulse + recovery covers the write cycle
  function automatic int unsigned recov_cycles(input int unsigned rec_min,
                                               input int unsigned wc_min,
                                               input int unsigned setup,
                                               input int unsigned pulse);
    int unsigned rest;
    rest = (wc_min > setup + pulse) ? wc_min - setup - pulse : 0;
    return umax(rec_min, rest);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned longest);
    int unsigned w;
    w = $clog2(longest + 1);
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> expire); // R1

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_cyc_pkg::*;
#(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned AS_CYC  = 1,
  parameter int unsigned PW_CYC  = 1,
  parameter int unsigned RCV_CYC = 1,
  parameter int unsigned RA_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expire,
  output phase_e           phase,
  output logic             accept,
  output logic             ld,
  output logic [CNT_W-1:0] ld_val,
  output logic             capture,
  output logic             wr_done,
  output logic             rd_valid
);
  localparam logic [CNT_W-1:0] AS_LD  = CNT_W'(AS_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LD  = CNT_W'(PW_CYC - 1);
  localparam logic [CNT_W-1:0] RCV_LD = CNT_W'(RCV_CYC - 1);
  localparam logic [CNT_W-1:0] RA_LD  = CNT_W'(RA_CYC - 1);

  phase_e nxt;
  logic   wr_last;

  assign accept  = (phase == PH_IDLE) && req_valid;
  assign capture = (phase == PH_RACC) && expire;
  assign wr_last = (phase == PH_WREC) && expire;

  always_comb begin
    nxt    = phase;
    ld     = 1'b0;
    ld_val = '0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        nxt    = req_write ? PH_WSET : PH_RACC;
        ld     = 1'b1;
        ld_val = req_write ? AS_LD : RA_LD;
      end
      PH_WSET: if (expire) begin
        nxt = PH_WPUL; ld = 1'b1; ld_val = PW_LD;
      end
      PH_WPUL: if (expire) begin
        nxt = PH_WREC; ld = 1'b1; ld_val = RCV_LD;
      end
      PH_WREC: if (expire) nxt = PH_IDLE;
      PH_RACC: if (expire) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      wr_done  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      phase    <= nxt;
      wr_done  <= wr_last;
      rd_valid <= capture;
    end
  end

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && rd_valid)); // R5
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_WDONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R5

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dout,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dout;
  end

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned DATA_W          = 4,
  parameter int unsigned CLK_PERIOD_NS   = 8,
  parameter int unsigned T_ADDR_SETUP_NS = 50,
  parameter int unsigned T_PULSE_NS      = 250,
  parameter int unsigned T_RECOV_NS      = 50,
  parameter int unsigned T_DATA_SETUP_NS = 200,
  parameter int unsigned T_SEL_SETUP_NS  = 250,
  parameter int unsigned T_ODIS_SETUP_NS = 200,
  parameter int unsigned T_ACCESS_NS     = 450,
  parameter int unsigned T_RD_CYCLE_NS   = 450,
  parameter int unsigned T_WR_CYCLE_NS   = 500,
  parameter bit          COMMON_IO       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_odis,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout
);
  localparam int unsigned AS_CYC  = ns_to_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned ODS_CYC = COMMON_IO ? ns_to_cycles(T_ODIS_SETUP_NS, CLK_PERIOD_NS) : 1;
  localparam int unsigned PW_CYC  = umax(umax(ns_to_cycles(T_PULSE_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS)),
                                         umax(ns_to_cycles(T_SEL_SETUP_NS, CLK_PERIOD_NS),
                                              ODS_CYC));
  localparam int unsigned WC_CYC  = ns_to_cycles(T_WR_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned RCV_CYC = recov_cycles(ns_to_cycles(T_RECOV_NS, CLK_PERIOD_NS),
                                                 WC_CYC, AS_CYC, PW_CYC);
  localparam int unsigned RA_CYC  = umax(ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_RD_CYCLE_NS, CLK_PERIOD_NS));
  localparam int unsigned CNT_W   = cnt_width(umax(umax(AS_CYC, PW_CYC), umax(RCV_CYC, RA_CYC)));

  phase_e           phase;
  logic             accept, ld, expire, capture;
  logic [CNT_W-1:0] ld_val;
  logic             selected;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expire(expire)
  );

  sram_cycle_fsm #(
    .CNT_W(CNT_W), .AS_CYC(AS_CYC), .PW_CYC(PW_CYC),
    .RCV_CYC(RCV_CYC), .RA_CYC(RA_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expire(expire), .phase(phase), .accept(accept), .ld(ld), .ld_val(ld_val),
    .capture(capture), .wr_done(wr_done), .rd_valid(rd_valid)
  );

  sram_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .mem_dout(mem_dout),
    .addr_q(mem_addr), .wdata_q(mem_din), .rdata_q(rd_data)
  );

  // RAM controls decoded from the registered phase
  assign selected  = (phase != PH_IDLE);
  assign mem_sel_n = !selected;
  assign mem_sel   = selected;
  assign mem_wr_n  = (phase != PH_WPUL);
  assign mem_odis  = (phase != PH_RACC);
  assign req_ready = (phase == PH_IDLE);

  AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_sel_n && mem_sel)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> ($stable(mem_addr) && $stable(mem_din))); // R5
  AST_ODIS_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_odis); // R6
  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_odis)); // R7
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

endmodule

// File: tb/sram_cycle_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctl_tb_top;
  localparam int P = 8;

  function automatic int cyc_of(input int ns);
    int c;
    c = ns / P;
    if (ns % P != 0) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1: expected phase lengths, restated from the nanosecond figures
  localparam int E_AS   = cyc_of(50);
  localparam int E_PW   = mx(mx(cyc_of(250), cyc_of(200)), mx(cyc_of(250), cyc_of(200)));
  localparam int E_RCV  = mx(cyc_of(50), cyc_of(500) - E_AS - E_PW);
  localparam int E_RA   = mx(cyc_of(450), cyc_of(450));
  localparam int E_WLAT = E_AS + E_PW + E_RCV;
  localparam int E_RLAT = E_RA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rd_valid, wr_done;
  logic [3:0] rd_data;
  logic [7:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_wr_n, mem_odis;
  logic [3:0] mem_din, mem_dout;

  always #4 clk = ~clk;

  sram_cycle_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_wr_n(mem_wr_n), .mem_odis(mem_odis), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural RAM with a cycle-counting timing monitor
  logic [3:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = ~i[3:0];
  wire sel_on = !mem_sel_n && mem_sel;
  assign mem_dout = (sel_on && mem_wr_n && !mem_odis) ? ram[mem_addr] : 4'h0;

  int  c_pre = 0, c_low = 0, c_post = 0, od_lo = 0;
  bit  saw_low = 0, in_sel = 0, prev_low = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      c_pre = 0; c_low = 0; c_post = 0; od_lo = 0;
      saw_low = 0; in_sel = 0; prev_low = 0;
    end else if (sel_on) begin
      in_sel = 1;
      if (!mem_odis) od_lo++;
      if (!mem_wr_n) begin c_low++; saw_low = 1; end
      else if (saw_low) c_post++;
      else c_pre++;
      if (mem_wr_n && prev_low) ram[mem_addr] = mem_din;
      prev_low = !mem_wr_n;
    end else if (in_sel) begin
      if (saw_low) begin
        chk(c_pre == E_AS, "R3 setup cycles", c_pre, E_AS);
        chk(c_low == E_PW, "R4 pulse cycles", c_low, E_PW);
        chk(c_post == E_RCV, "R5 recovery cycles", c_post, E_RCV);
        chk(od_lo == 0, "R6 odis low in write", od_lo, 0);
      end else begin
        chk(c_pre == E_RA, "R7 access cycles", c_pre, E_RA);
        chk(od_lo == c_pre, "R7 output enabled", od_lo, c_pre);
      end
      c_pre = 0; c_low = 0; c_post = 0; od_lo = 0;
      saw_low = 0; in_sel = 0; prev_low = 0;
    end
  end

  task automatic do_txn(input bit wr, input logic [7:0] a, input logic [3:0] d,
                        output int lat, output logic [3:0] rdat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!(wr ? wr_done : rd_valid) && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    rdat = rd_data;
  endtask

  // {write, addr, data or expected read data}
  localparam logic [12:0] VEC [10] = '{
    {1'b1, 8'h00, 4'h3}, {1'b1, 8'hFF, 4'hC}, {1'b1, 8'h5A, 4'h9},
    {1'b0, 8'h00, 4'h3}, {1'b0, 8'hFF, 4'hC}, {1'b0, 8'h5A, 4'h9},
    {1'b1, 8'h00, 4'h6}, {1'b0, 8'h00, 4'h6}, {1'b0, 8'h01, 4'hE},
    {1'b0, 8'h80, 4'hF}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [3:0] rd;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(req_ready == 1, "R2 ready", req_ready, 1);
    chk(mem_sel_n == 1, "R2 sel_n", mem_sel_n, 1);
    chk(mem_sel == 0, "R2 sel", mem_sel, 0);
    chk(mem_wr_n == 1, "R2 wr_n", mem_wr_n, 1);
    chk(mem_odis == 1, "R2 odis", mem_odis, 1);
    chk(rd_valid == 0 && wr_done == 0, "R2 strobes", {rd_valid, wr_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && mem_wr_n == 1, "R2 after release", {req_ready, mem_wr_n}, 3);

    for (int v = 0; v < 10; v++) begin
      do_txn(VEC[v][12], VEC[v][11:4], VEC[v][3:0], lat, rd);
      if (VEC[v][12]) chk(lat == E_WLAT, "R5 write latency", lat, E_WLAT);
      else begin
        chk(lat == E_RLAT, "R7 read latency", lat, E_RLAT);
        chk(rd == VEC[v][3:0], "R7 read data", rd, VEC[v][3:0]);
      end
    end

    // R8: requests while busy are ignored
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 4'hA;
    @(negedge clk);
    req_addr = 8'h34; req_wdata = 4'h5;
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 0, "R8 ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!wr_done) @(negedge clk);
    do_txn(1'b0, 8'h34, 4'h0, lat, rd);
    chk(rd == 4'hB, "R8 busy request ignored", rd, 4'hB);
    do_txn(1'b0, 8'h33, 4'h0, lat, rd);
    chk(rd == 4'hA, "R3 accepted write stored", rd, 4'hA);

    // R2: asynchronous reset in mid-pulse
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 4'h7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (E_AS + 3) @(negedge clk);
    chk(mem_wr_n == 0, "R4 strobe low mid-write", mem_wr_n, 0);
    @(posedge clk); #2 rst_n = 1'b0;
    @(negedge clk);
    chk(mem_wr_n == 1 && mem_sel_n == 1 && mem_sel == 0, "R2 reset aborts write",
        {mem_wr_n, mem_sel_n, mem_sel}, 6);
    chk(req_ready == 1 && mem_odis == 1, "R2 reset idle", {req_ready, mem_odis}, 3);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_txn(1'b0, 8'h5A, 4'h0, lat, rd);
    chk(rd == 4'h9 && lat == E_RLAT, "R7 read after reset", rd, 4'h9);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule